// File: doc/BRIEF.md
# I2C Target Write Receiver

This block is the receive side of a 7-bit-address I2C target. It runs on a system clock much faster than the bus. Both bus lines are first synchronised and then cleaned by a glitch filter. Single-cycle rise and fall pulses are derived from the filtered levels. From these the block recognises START and STOP conditions, shifts in address and data bits, and checks the address byte against its own address. For acknowledge it drives an open-drain SDA output low; at all other times that output is released.

SDA is not sampled at the moment the filtered SCL is seen to fall. The value used comes from a short delay line on the filtered SDA level. That value is the line level a fixed number of system ticks before the falling edge was detected. A small skew between the two filtered lines therefore cannot move a data transition into the sampled bit. Each received data byte is offered on a valid/ready byte port. Clock stretching, 10-bit addressing, read transfers and arbitration between several masters are not supported.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset, sda_o is 1 (released) and rx_valid_o is 0. Whenever the block is idle, sda_o stays 1.
- R2: A level change on scl_i or sda_i that lasts fewer than FILT_LEN consecutive system clocks is ignored. It never counts as a bit clock, START or STOP.
- R3: Each SCL rise or fall produces exactly one single-cycle edge pulse, so each SCL clock shifts in exactly one bit.
- R4: SDA falling while SCL is high is a START and begins address reception. A START seen in any state, including a repeated START in the middle of a transfer, restarts address reception with an empty bit count.
- R5: Bits are shifted in MSB first. The value taken for each bit is the filtered SDA level SDA_TAP system ticks before the detected SCL falling edge. SDA_TAP must be less than SCL_HIGH_MIN, and an elaboration check rejects any other setting.
- R6: The address byte is accepted when bits 7..1 equal own_addr_i and bit 0 (direction) is 0 (write). The block then drives sda_o low for the ninth SCL clock and releases it at that clock's falling edge.
- R7: A rejected address byte (different address, or direction bit 1) is not acknowledged (sda_o stays 1). The block goes idle, and later bytes up to the next START produce neither ACK nor rx_valid_o.
- R8: After the eighth bit of each data byte, the byte appears on rx_data_o with rx_valid_o = 1, and the block drives sda_o low for the ninth SCL clock.
- R9: rx_valid_o stays 1 and rx_data_o stays unchanged until a cycle with rx_ready_i = 1, which clears rx_valid_o. A byte that completes while the previous one is still pending replaces it.
- R10: SDA rising while SCL is high is a STOP. It returns the block to idle from any state with sda_o released, and bus activity without a new START is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr_i | input | 7 | Target address to match |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_o | output | 1 | Open-drain SDA control: 0 pulls low, 1 releases |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | Data byte pending |
| rx_ready_i | input | 1 | Consumer accepts the pending byte |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at START and STOP. SCL stays high for longer than SDA_TAP plus the filter latency. The consumer never sees a second byte complete before it accepts the first, so rx_data_o stability is checked only outside data reception. The bench drives the bus from a master model with quarter-bit phases of 25 system clocks. It wires SDA as a wired-AND of master and target, and injects glitches only as pulses of two clocks, shorter than the filter length.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_DATA     = 3'd3,
    ST_DATA_ACK = 3'd4
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
// Synchroniser, persistence filter and edge pulse former for one bus line.
module i2c_line_cond #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       run_q;
  logic                lvl_q, lvl_d_q;
  logic                s_lvl;

  assign s_lvl = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_LEN-2:0], raw_i};
  end

  // the level flips only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (s_lvl != lvl_q) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        lvl_q <= s_lvl;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_d_q <= 1'b1;
    else     lvl_d_q <= lvl_q;
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~lvl_d_q;
  assign fall_o = ~lvl_q & lvl_d_q;
endmodule

// File: rtl/i2c_tap_delay.sv
// Fixed delay line: out is the input as it was DEPTH cycles earlier.
module i2c_tap_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] line_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) line_q <= '1;
        else     line_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) line_q <= '1;
        else     line_q <= {line_q[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = line_q[DEPTH-1];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              bit_i,
  input  logic              ready_i,
  output logic              sda_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output tgt_state_e        state_o
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  tgt_state_e        state_q, nxt;
  logic [BCW-1:0]    cnt_q;
  logic [BYTE_W-1:0] sh_q, byte_nx;
  logic              hi_seen_q, bit_evt;
  logic              ack_nx, deliver;
  logic              addr_ok;

  assign bit_evt = scl_fall_i & hi_seen_q;
  assign byte_nx = {sh_q[BYTE_W-2:0], bit_i};
  assign addr_ok = (byte_nx[BYTE_W-1 -: ADDR_W] == own_addr_i) && !byte_nx[0];

  // every branch assigns nxt, deliver, ack_nx in that order
  always_comb begin
    unique case (state_q)
      ST_ADDR: begin
        nxt     = (bit_evt && cnt_q == LAST_BIT) ? (addr_ok ? ST_ADDR_ACK : ST_IDLE) : ST_ADDR;
        deliver = 1'b0;
        ack_nx  = 1'b0;
      end
      ST_ADDR_ACK: begin
        nxt     = bit_evt ? ST_DATA : ST_ADDR_ACK;
        deliver = 1'b0;
        ack_nx  = 1'b0;
      end
      ST_DATA: begin
        nxt     = (bit_evt && cnt_q == LAST_BIT) ? ST_DATA_ACK : ST_DATA;
        deliver = bit_evt && cnt_q == LAST_BIT;
        ack_nx  = 1'b0;
      end
      ST_DATA_ACK: begin
        nxt     = bit_evt ? ST_DATA : ST_DATA_ACK;
        deliver = 1'b0;
        ack_nx  = 1'b0;
      end
      default: begin
        nxt     = ST_IDLE;
        deliver = 1'b0;
        ack_nx  = 1'b0;
      end
    endcase
    if (stop_i) begin
      nxt     = ST_IDLE;
      deliver = 1'b0;
    end else if (start_i) begin
      nxt     = ST_ADDR;
      deliver = 1'b0;
    end
    ack_nx = (nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      hi_seen_q <= 1'b0;
      sda_o     <= 1'b1;
    end else begin
      state_q <= nxt;
      sda_o   <= ~ack_nx;
      if (start_i || nxt != state_q) cnt_q <= '0;
      else if (bit_evt)              cnt_q <= cnt_q + 1'b1;
      if (bit_evt) sh_q <= byte_nx;
      if (start_i || scl_fall_i) hi_seen_q <= 1'b0;
      else if (scl_rise_i)       hi_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (deliver) begin
      valid_o <= 1'b1;
      data_o  <= byte_nx;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_LEN     = 2,
  parameter int FILT_LEN     = 3,
  parameter int SDA_TAP      = 4,
  parameter int SCL_HIGH_MIN = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] own_addr_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i
);
  localparam int NLINES = 2;
  localparam int L_SCL  = 0;
  localparam int L_SDA  = 1;

  generate
    if (SDA_TAP >= SCL_HIGH_MIN) begin : g_bad_tap
      $error("SDA_TAP must be below SCL_HIGH_MIN");
    end
  endgenerate

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic              sda_tap, start_evt, stop_evt;
  tgt_state_e        fsm_state;

  assign raw[L_SCL] = scl_i;
  assign raw[L_SDA] = sda_i;

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_line_cond #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_cond (
        .clk(clk), .rst(rst), .raw_i(raw[g]),
        .lvl_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
      );
    end
  endgenerate

  i2c_tap_delay #(.DEPTH(SDA_TAP)) u_tap (
    .clk(clk), .rst(rst), .d_i(lvl[L_SDA]), .q_o(sda_tap)
  );

  assign start_evt = lvl[L_SCL] & fall[L_SDA];
  assign stop_evt  = lvl[L_SCL] & rise[L_SDA];

  i2c_tgt_fsm #(.ADDR_W(7), .BYTE_W(8)) u_fsm (
    .clk(clk), .rst(rst), .own_addr_i(own_addr_i),
    .start_i(start_evt), .stop_i(stop_evt),
    .scl_rise_i(rise[L_SCL]), .scl_fall_i(fall[L_SCL]),
    .bit_i(sda_tap), .ready_i(rx_ready_i),
    .sda_o(sda_o), .data_o(rx_data_o), .valid_o(rx_valid_o),
    .state_o(fsm_state)
  );
endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sda_o,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input tgt_state_e state,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt
);
  a_r3_rise_one_cycle: assert property (@(posedge clk) disable iff (rst)
    scl_rise |=> !scl_rise);
  a_r3_fall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    scl_fall |=> !scl_fall);
  a_r4_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_evt && !stop_evt |=> state == ST_ADDR);
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> state == ST_IDLE);
  a_r6_low_only_ack: assert property (@(posedge clk) disable iff (rst)
    !sda_o |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK));
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> sda_o);
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);
  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o && !rx_ready_i && state != ST_DATA |=> $stable(rx_data_o));
  a_r8_valid_after_data: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid_o) |-> state == ST_DATA_ACK);
endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
  .clk(clk), .rst(rst), .sda_o(sda_o), .rx_data_o(rx_data_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .state(fsm_state),
  .scl_rise(rise[0]), .scl_fall(fall[0]),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/test_i2c_tgt_rx.sv
module test_i2c_tgt_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam logic [6:0] OWN = 7'h50;
  localparam int NV = 5;
  // {address byte, data byte, address expected to be acknowledged}
  localparam logic [16:0] VEC [NV] = '{
    {8'hA0, 8'hA5, 1'b1},
    {8'hA2, 8'h3C, 1'b0},
    {8'hA1, 8'h00, 1'b0},
    {8'hA0, 8'h00, 1'b1},
    {8'hA0, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, m_sda = 1'b1, rx_ready = 1'b0;
  logic sda_bus, sda_o, rx_valid;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & sda_o;

  i2c_tgt_rx #(.SYNC_LEN(2), .FILT_LEN(3), .SDA_TAP(4), .SCL_HIGH_MIN(40)) i_i2c_tgt_rx (
    .clk(clk), .rst(rst), .own_addr_i(OWN), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; ticks(Q);
    scl = 1'b1; ticks(Q);
    m_sda = 1'b0; ticks(Q);
    scl = 1'b0; ticks(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; ticks(Q);
    scl = 1'b1; ticks(Q);
    m_sda = 1'b1; ticks(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      ticks(Q/2); scl = 1'b1; ticks(2); scl = 1'b0; ticks(Q - Q/2 - 2);
    end else ticks(Q);
    scl = 1'b1;
    if (glitch && b) begin
      ticks(Q); m_sda = 1'b0; ticks(2); m_sda = 1'b1; ticks(Q - 2);
    end else ticks(2*Q);
    scl = 1'b0; ticks(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch);
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
  endtask

  task automatic ack_bit(output logic got);
    m_sda = 1'b1; ticks(Q);
    scl = 1'b1; ticks(Q);
    got = sda_bus; ticks(Q);
    scl = 1'b0; ticks(Q);
  endtask

  task automatic accept();
    rx_ready = 1'b1; ticks(1); rx_ready = 1'b0; ticks(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic got;
    logic [16:0] v;
    ticks(4);
    rst = 1'b0;
    ticks(2);
    // R1 reset state
    check(sda_o == 1'b1, "R1", "sda_o after reset", sda_o, 1);
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    ticks(Q);

    // vector table walk: R6 R7 R8 R9 R10 R5 R3
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      bus_start();
      send_byte(v[16:9], 1'b0);
      ack_bit(got);
      check(got == ~v[0], v[0] ? "R6" : "R7", "address ack level", got, ~v[0]);
      send_byte(v[8:1], 1'b0);
      ack_bit(got);
      if (v[0]) begin
        check(got == 1'b0, "R8", "data ack level", got, 0);
        check(rx_valid == 1'b1, "R8", "rx_valid after byte", rx_valid, 1);
        check(rx_data == v[8:1], "R5 R3", "rx_data msb first", rx_data, v[8:1]);
        ticks(20);
        check(rx_valid == 1'b1 && rx_data == v[8:1], "R9", "hold until ready", rx_data, v[8:1]);
        accept();
        check(rx_valid == 1'b0, "R9", "valid cleared by ready", rx_valid, 0);
      end else begin
        check(got == 1'b1, "R7", "no data ack after reject", got, 1);
        check(rx_valid == 1'b0, "R7", "no byte after reject", rx_valid, 0);
      end
      bus_stop();
      ticks(Q);
      check(sda_o == 1'b1, "R10", "released after stop", sda_o, 1);
    end

    // R4 repeated START mid data byte restarts address reception
    bus_start();
    send_byte(8'hA0, 1'b0);
    ack_bit(got);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    bus_start();
    send_byte(8'hA0, 1'b0);
    ack_bit(got);
    check(got == 1'b0, "R4", "ack after repeated start", got, 0);
    check(rx_valid == 1'b0, "R4", "partial byte not delivered", rx_valid, 0);
    send_byte(8'h81, 1'b0);
    ack_bit(got);
    check(rx_valid == 1'b1 && rx_data == 8'h81, "R4", "byte after repeated start", rx_data, 8'h81);
    accept();
    bus_stop();
    ticks(Q);

    // R10 STOP mid address, then traffic without START is ignored
    bus_start();
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    bus_stop();
    ticks(Q);
    check(sda_o == 1'b1, "R10", "released after early stop", sda_o, 1);
    scl = 1'b0; ticks(Q);
    send_byte(8'hA0, 1'b0);
    ack_bit(got);
    check(got == 1'b1, "R10", "no ack without start", got, 1);
    send_byte(8'h55, 1'b0);
    ack_bit(got);
    check(rx_valid == 1'b0, "R10", "no byte without start", rx_valid, 0);
    m_sda = 1'b0; ticks(Q);
    bus_stop();
    ticks(Q);

    // R2 short glitches on both lines
    bus_start();
    send_byte(8'hA0, 1'b1);
    ack_bit(got);
    check(got == 1'b0, "R2", "ack despite glitches", got, 0);
    send_byte(8'hB6, 1'b1);
    ack_bit(got);
    check(rx_valid == 1'b1 && rx_data == 8'hB6, "R2", "byte despite glitches", rx_data, 8'hB6);
    accept();
    bus_stop();
    ticks(Q);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule